// File: doc/BRIEF.md
# Streaming Checksum Byte Unit

This unit watches a stream of bytes, one per cycle when `inValid` is high, grouped into blocks whose final byte carries `inLast`. It keeps a running 8-bit sum of the block and drops every carry out of the top bit. It works in one of two modes. In generate mode it emits the two's complement of that sum, which is the byte to store alongside the data. In check mode the final byte of the block is the stored checksum. The unit reports pass when the whole block, checksum included, sums to zero, and fail when it does not.

For every accepted byte it also delivers a parity bit one cycle later. The polarity is chosen per byte. Under even polarity the bit makes the total count of ones even, and under odd polarity it makes the count odd. Blocks may follow one another with no idle cycle between them.

Top module: `cksum_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sumValid`, `checkPass`, `checkFail` and `parityValid` are low, and `sumOut` reads 0x00.
- R2: In generate mode (`modeCheck`=0), the cycle after a byte with `inValid`=1 and `inLast`=1 has `sumValid`=1 for exactly that one cycle. `sumOut` then equals the two's complement, mod 256, of the sum of all bytes in the block including the last one. For example, 0x38, 0x23, 0x33, 0x07 gives 0x6B.
- R3: In check mode (`modeCheck`=1), the cycle after the last byte raises exactly one of `checkPass` and `checkFail` for one cycle. `checkPass` is raised when the mod-256 sum of every byte of the block, the final checksum byte included, is 0x00.
- R4: The sum wraps modulo 256. A block of 0xFF, 0xFF, 0xFF produces the checksum 0x03.
- R5: After a byte flagged last, the running sum restarts from zero, so a block that begins in the very next cycle is unaffected by the previous one.
- R6: A cycle with `inValid`=0 changes nothing. Its `inByte` is not summed, its `inLast` closes no block, and the following cycle shows no result flag.
- R7: The cycle after each byte with `inValid`=1 has `parityValid`=1. With `parityOdd`=0 sampled with the byte, `parityOut` is 1 when the byte has an odd number of ones. With `parityOdd`=1, `parityOut` is 1 when the byte has an even number of ones.
- R8: The mode is taken from `modeCheck` in the cycle of the last byte only. `sumValid` never rises together with `checkPass` or `checkFail`.
- R9: A block made of its last byte alone is summed as that single byte. In generate mode the result is the negated byte. In check mode the block passes only when that byte is 0x00, the checksum of an empty block.
- R10: A reset in the middle of a block discards the partial sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| modeCheck | input | 1 | 0 = generate checksum, 1 = check block |
| parityOdd | input | 1 | 0 = even parity, 1 = odd parity |
| inByte | input | 8 | Byte in |
| inValid | input | 1 | `inByte` is present this cycle |
| inLast | input | 1 | The present byte ends its block |
| sumOut | output | 8 | Generated checksum byte |
| sumValid | output | 1 | `sumOut` holds a fresh checksum this cycle |
| checkPass | output | 1 | Checked block summed to zero |
| checkFail | output | 1 | Checked block summed to non-zero |
| parityOut | output | 1 | Parity bit of the previous accepted byte |
| parityValid | output | 1 | `parityOut` is fresh this cycle |

## Verification
The closing byte of one block and the opening byte of the next can arrive in adjacent cycles. In that case the previous block's result is published in the same cycle as the new block's first byte is summed, and that cycle also carries the parity of the closing byte. The bench sends blocks back to back with no idle cycle. It judges the second block's checksum against a sum started from zero and checks, in the same sample, the result flags of the first block and the parity of its closing byte. Mode switches between the inner bytes and the closing byte of a block check that the result follows only the closing byte's mode.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic takeByte;    // a byte is present and is summed
    logic closeBlock;  // the present byte ends its block
    logic genMode;     // the closing byte asks for a generated checksum
  } cksumStrobe_t;
endpackage

// File: rtl/cksum_ctrl.sv
module cksum_ctrl
  import cksum_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inLast,
  input  logic         modeCheck,
  input  logic         totalZero,
  output cksumStrobe_t strobe,
  output logic         sumValid,
  output logic         checkPass,
  output logic         checkFail,
  output logic         parityValid
);
  always_comb begin
    strobe.takeByte   = inValid;
    strobe.closeBlock = inValid & inLast;
    strobe.genMode    = ~modeCheck;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumValid    <= 1'b0;
      checkPass   <= 1'b0;
      checkFail   <= 1'b0;
      parityValid <= 1'b0;
    end else begin
      sumValid    <= strobe.closeBlock & strobe.genMode;
      checkPass   <= strobe.closeBlock & ~strobe.genMode & totalZero;
      checkFail   <= strobe.closeBlock & ~strobe.genMode & ~totalZero;
      parityValid <= strobe.takeByte;
    end
  end
endmodule

// File: rtl/cksum_dp.sv
module cksum_dp
  import cksum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cksumStrobe_t      strobe,
  input  logic [DATA_W-1:0] inByte,
  input  logic              parityOdd,
  output logic              totalZero,
  output logic [DATA_W-1:0] sumOut,
  output logic              parityOut
);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] runTotal;
  logic [DATA_W:0]   xorChain;

  // carry out of the top bit is simply not kept
  assign runTotal  = acc + inByte;
  assign totalZero = (runTotal == ZERO);

  // parity reduction as an explicit chain, seeded with the polarity
  assign xorChain[0] = parityOdd;
  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign xorChain[i+1] = xorChain[i] ^ inByte[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= ZERO;
      sumOut    <= ZERO;
      parityOut <= 1'b0;
    end else if (strobe.takeByte) begin
      acc       <= strobe.closeBlock ? ZERO : runTotal;
      parityOut <= xorChain[DATA_W];
      if (strobe.closeBlock && strobe.genMode) sumOut <= ~runTotal + 1'b1;
    end
  end
endmodule

// File: rtl/cksum_unit.sv
module cksum_unit
  import cksum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeCheck,
  input  logic              parityOdd,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  input  logic              inLast,
  output logic [DATA_W-1:0] sumOut,
  output logic              sumValid,
  output logic              checkPass,
  output logic              checkFail,
  output logic              parityOut,
  output logic              parityValid
);
  cksumStrobe_t strobe;
  logic         totalZero;

  cksum_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .modeCheck(modeCheck), .totalZero(totalZero), .strobe(strobe),
    .sumValid(sumValid), .checkPass(checkPass), .checkFail(checkFail),
    .parityValid(parityValid)
  );

  cksum_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inByte(inByte),
    .parityOdd(parityOdd), .totalZero(totalZero), .sumOut(sumOut),
    .parityOut(parityOut)
  );
endmodule

// File: rtl/cksum_unit_chk.sv
module cksum_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              modeCheck,
  input logic              parityOdd,
  input logic [DATA_W-1:0] inByte,
  input logic              inValid,
  input logic              inLast,
  input logic [DATA_W-1:0] sumOut,
  input logic              sumValid,
  input logic              checkPass,
  input logic              checkFail,
  input logic              parityOut,
  input logic              parityValid
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sumValid && !checkPass && !checkFail && !parityValid));

  a_r2_gen_follows_last: assert property (@(posedge clk) disable iff (rst)
    (inValid && inLast && !modeCheck) |=> sumValid);

  a_r2_gen_only_after_last: assert property (@(posedge clk) disable iff (rst)
    sumValid |-> $past(inValid && inLast && !modeCheck));

  a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
    !(checkPass && checkFail));

  a_r3_verdict_follows_last: assert property (@(posedge clk) disable iff (rst)
    (inValid && inLast && modeCheck) |=> (checkPass || checkFail));

  a_r8_no_mix: assert property (@(posedge clk) disable iff (rst)
    !(sumValid && (checkPass || checkFail)));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!sumValid && !checkPass && !checkFail && !parityValid));

  a_r7_parity_value: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (parityValid && (parityOut == ((^$past(inByte)) ^ $past(parityOdd)))));
endmodule

bind cksum_unit cksum_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .modeCheck(modeCheck), .parityOdd(parityOdd),
  .inByte(inByte), .inValid(inValid), .inLast(inLast), .sumOut(sumOut),
  .sumValid(sumValid), .checkPass(checkPass), .checkFail(checkFail),
  .parityOut(parityOut), .parityValid(parityValid)
);

// File: tb/tb_cksum_unit.sv
`timescale 1ns/1ps
module tb_cksum_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeCheck = 1'b0;
  logic       parityOdd = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic [7:0] sumOut;
  logic       sumValid, checkPass, checkFail, parityOut, parityValid;

  int total = 0;
  int fails = 0;
  logic [7:0] blk [0:15];

  always #2.5 clk = ~clk;

  cksum_unit dut (
    .clk(clk), .rst(rst), .modeCheck(modeCheck), .parityOdd(parityOdd),
    .inByte(inByte), .inValid(inValid), .inLast(inLast), .sumOut(sumOut),
    .sumValid(sumValid), .checkPass(checkPass), .checkFail(checkFail),
    .parityOut(parityOut), .parityValid(parityValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic sendByte(input logic [7:0] b, input bit last, input bit mode, input bit pol);
    inByte = b; inValid = 1'b1; inLast = last; modeCheck = mode; parityOdd = pol;
    @(negedge clk);
  endtask

  task automatic sendIdle(input logic [7:0] junk);
    inByte = junk; inValid = 1'b0; inLast = 1'b1; modeCheck = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit expParity(input logic [7:0] b, input bit pol);
    int ones = 0;
    for (int k = 0; k < 8; k++) ones += b[k];
    return pol ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  task automatic checkResult(input logic [7:0] s, input bit mode, input string req);
    if (!mode) begin
      chk(sumValid == 1'b1, req, sumValid, 1);
      chk(sumOut == 8'(-s), req, sumOut, 8'(-s));
      chk(!checkPass && !checkFail, req, {checkPass, checkFail}, 0);
    end else begin
      chk(checkPass == (s == 8'h00), req, checkPass, (s == 8'h00));
      chk(checkFail == (s != 8'h00), req, checkFail, (s != 8'h00));
      chk(sumValid == 1'b0, req, sumValid, 0);
    end
  endtask

  // sends blk[0..n-1]; inner bytes must raise no result flag
  task automatic runBlock(input int n, input bit mode, input string req);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) begin
      s = s + blk[i];
      sendByte(blk[i], i == n - 1, mode, 1'b0);
      if (i < n - 1)
        chk(!sumValid && !checkPass && !checkFail, req, {sumValid, checkPass, checkFail}, 0);
    end
    checkResult(s, mode, req);
  endtask

  task automatic idleQuiet(input string req);
    sendIdle(8'hA5);
    chk(!sumValid && !checkPass && !checkFail && !parityValid, req,
        {sumValid, checkPass, checkFail, parityValid}, 0);
  endtask

  initial begin
    #150000;
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: outputs quiet while in reset
    chk(!sumValid && !checkPass && !checkFail && !parityValid, "R1",
        {sumValid, checkPass, checkFail, parityValid}, 0);
    chk(sumOut == 8'h00, "R1", sumOut, 0);
    rst = 1'b0;
    idleQuiet("R1");

    // R7: parity over every byte and both polarities
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 256; b++) begin
        sendByte(8'(b), 1'b0, 1'b0, p[0]);
        chk(parityValid == 1'b1, "R7", parityValid, 1);
        chk(parityOut == expParity(8'(b), p[0]), "R7", parityOut, expParity(8'(b), p[0]));
      end
    sendByte(8'h00, 1'b1, 1'b0, 1'b0); // close the sweep block
    idleQuiet("R6");

    // R9 / R2: single-byte blocks in generate mode, all values
    for (int b = 0; b < 256; b++) begin
      blk[0] = 8'(b);
      runBlock(1, 1'b0, "R9 gen");
    end
    idleQuiet("R2 one cycle");

    // R9 / R3: single-byte blocks in check mode; only 0x00 passes
    for (int b = 0; b < 256; b++) begin
      blk[0] = 8'(b);
      runBlock(1, 1'b1, "R9 chk");
    end
    idleQuiet("R3 one cycle");

    // R2: worked example gives 0x6B
    blk[0] = 8'h38; blk[1] = 8'h23; blk[2] = 8'h33; blk[3] = 8'h07;
    runBlock(4, 1'b0, "R2 example");
    chk(sumOut == 8'h6B, "R2 example", sumOut, 8'h6B);
    idleQuiet("R2 one cycle");
    blk[4] = 8'h6B;
    runBlock(5, 1'b1, "R3 example pass");
    blk[4] = 8'h6C;
    runBlock(5, 1'b1, "R3 example fail");
    idleQuiet("R3 one cycle");

    // R4: wrap-around
    blk[0] = 8'hFF; blk[1] = 8'hFF; blk[2] = 8'hFF;
    runBlock(3, 1'b0, "R4");
    chk(sumOut == 8'h03, "R4", sumOut, 8'h03);
    blk[3] = 8'h03;
    runBlock(4, 1'b1, "R4 check");

    // R5: back to back blocks; second block result independent of first
    blk[0] = 8'h10; blk[1] = 8'h20;
    runBlock(2, 1'b0, "R5 first");
    blk[0] = 8'h01;
    runBlock(1, 1'b0, "R5 second");
    chk(sumOut == 8'hFF, "R5", sumOut, 8'hFF);
    // mixed: check block then immediate generate block
    blk[0] = 8'h40; blk[1] = 8'hC0;
    runBlock(2, 1'b1, "R5 check then gen");
    blk[0] = 8'h02;
    runBlock(1, 1'b0, "R5 gen after check");
    chk(parityOut == expParity(8'h02, 1'b0), "R5 parity same cycle", parityOut, expParity(8'h02, 1'b0));

    // R6: idle cycles with junk and inLast inside a block
    sendByte(8'h11, 1'b0, 1'b0, 1'b0);
    sendIdle(8'h77);
    chk(!sumValid && !parityValid, "R6 gap", {sumValid, parityValid}, 0);
    sendIdle(8'hEE);
    sendByte(8'h22, 1'b1, 1'b0, 1'b0);
    checkResult(8'h33, 1'b0, "R6");

    // R8: mode taken at the closing byte only
    sendByte(8'h05, 1'b0, 1'b1, 1'b0);
    sendByte(8'h06, 1'b1, 1'b0, 1'b0);
    checkResult(8'h0B, 1'b0, "R8 gen at close");
    sendByte(8'h05, 1'b0, 1'b0, 1'b0);
    sendByte(8'hFB, 1'b1, 1'b1, 1'b0);
    checkResult(8'h00, 1'b1, "R8 check at close");

    // R10: reset mid-block discards partial sum
    sendByte(8'h55, 1'b0, 1'b0, 1'b0);
    sendByte(8'h66, 1'b0, 1'b0, 1'b0);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    blk[0] = 8'h01;
    runBlock(1, 1'b0, "R10");
    chk(sumOut == 8'hFF, "R10", sumOut, 8'hFF);
    idleQuiet("R10 idle");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule